// File: doc/BRIEF.md
# Four-Channel PWM Generator with Period-Boundary Updates

This block produces four independent pulse-width-modulated outputs. Each channel owns a counter, a period value, a duty value and a mode word. The mode word picks a counting rate from a shared power-of-two prescaler, left-aligned or center-aligned counting, the output's starting level, and which value a buffered update replaces. All registers are loaded through one write-only port.

Period and duty can only be loaded directly while a channel is stopped. While it runs, new values go through a per-channel update register. The held value is applied only when the current period ends, so a waveform is never cut short or stretched in mid-cycle.

A start mask and a stop mask act on several channels in one write. Channels started together with the same rate and period stay in phase. Each completed period raises a one-clock pulse, gated by a per-channel enable, and sets a sticky flag that software clears by writing ones.

Top module: `pwm_multi`

## Requirements
- R1: After synchronous reset, every channel is stopped. `ch_active`, `irq_pulse` and `eop_status` are all zero, and every `pwm_out` bit is 1, which is the stopped level for polarity 0.
- R2: Address map. When `wr_addr[7]`=0, the low two bits select a global register: 0 start mask, 1 stop mask, 2 event-pulse enable mask, 3 status clear mask. When `wr_addr[7]`=1, `wr_addr[6:4]` must be 0, channel n is `wr_addr[3:2]`, and the low two bits select 0 mode, 1 period, 2 duty, 3 update. Mode bits of `wr_data`: [2:0] rate select, [3] center-aligned, [4] polarity, [5] update target (1 = period, 0 = duty).
- R3: In left-aligned mode the counter runs 0 to period-1 and then wraps to 0. While running, the output equals the polarity bit when count < duty, and its inverse otherwise.
- R4: In center-aligned mode the counter counts 0 up to period, then down to 0. The period ends when the count returns from 1 to 0. The output rule is the same as in R3.
- R5: A channel's counter advances once every 2^s clocks, where s is its rate select. The steps fall on the cycles where the low s bits of a free-running counter, cleared by reset, are all ones.
- R6: A stopped channel drives the inverse of its polarity bit.
- R7: Writes to the period or duty register of a running channel are ignored.
- R8: An update write to a running channel is held until its period ends. The value is then loaded into the period or the duty register, as the update-target bit chooses, and takes effect from the next period. A later update write replaces a held one.
- R9: Channels started by a single start-mask write begin counting from 0 on the same clock. If they share a rate and a period, their outputs stay identical. Starting a channel that is already running has no effect.
- R10: A stop-mask bit stops that channel, clears its count, and discards any held update.
- R11: Each period end raises `irq_pulse` for one clock on the next cycle if the channel's event enable is set. It always sets the channel's `eop_status` bit. A status bit clears only when a clear-mask write has a 1 in that position, and a new period end in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 32 | Register write data |
| pwm_out | output | 4 | Waveform output per channel |
| ch_active | output | 4 | Channel running flags |
| irq_pulse | output | 4 | Gated one-clock end-of-period pulse |
| eop_status | output | 4 | Sticky end-of-period flags |

## Verification
The channels are started together with different mixes of alignment, polarity and rate. This separates an up/down turnaround error from a wrap error, and separates a prescaler-tap error from a compare error. Update writes of both targets are issued in mid-period, so a commit made too early or aimed at the wrong register shows up as a waveform edge in the wrong cycle. A stop issued while an update is held, followed by a restart, shows whether the held value was discarded. The direct writes to a running channel, and the boundary duties of 0, equal to the period, and the 14-of-15 case, cover the ignore and compare limits.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int NCH    = 4;
    localparam int CW     = 16;
    localparam int SELW   = 3;
    localparam int NSRC   = 1 << SELW;
    localparam int AW     = 8;
    localparam int DW     = 32;
    localparam int CHW    = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int MODE_W = SELW + 3;

    typedef struct packed {
        logic            upd_prd;
        logic            pol;
        logic            center;
        logic [SELW-1:0] csel;
    } mode_t;

    typedef enum logic [1:0] {
        G_START = 2'd0,
        G_STOP  = 2'd1,
        G_IEN   = 2'd2,
        G_CLR   = 2'd3
    } greg_e;

    typedef enum logic [1:0] {
        C_MODE = 2'd0,
        C_PRD  = 2'd1,
        C_DUTY = 2'd2,
        C_UPD  = 2'd3
    } creg_e;

    function automatic logic at_end(input mode_t m, input logic dn,
                                    input logic [CW-1:0] c, input logic [CW-1:0] p);
        if (m.center)
            return dn && (c <= CW'(1));
        return ({1'b0, c} + (CW+1)'(1)) >= {1'b0, p};
    endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [NSRC-1:0] tick
);
    logic [NSRC-2:0] div;

    always_ff @(posedge clk) begin
        if (rst) div <= '0;
        else     div <= div + 1'b1;
    end

    assign tick[0] = 1'b1;
    for (genvar k = 1; k < NSRC; k++) begin : g_tap
        assign tick[k] = &div[k-1:0];
    end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] tick,
    input  logic            start,
    input  logic            stop,
    input  mode_t           mode,
    input  logic            wr_prd,
    input  logic            wr_duty,
    input  logic            wr_upd,
    input  logic [CW-1:0]   wdata,
    output logic            active,
    output logic            pwm,
    output logic            eop
);
    logic [CW-1:0] cnt, prd, duty, pval, cnt_nx;
    logic          dn, dn_nx, pend, step, launch;

    assign step   = active && tick[mode.csel];
    assign eop    = step && at_end(mode, dn, cnt, prd);
    assign launch = start && !active;
    assign pwm    = active ? ((cnt < duty) ? mode.pol : ~mode.pol) : ~mode.pol;

    always_comb begin
        cnt_nx = cnt + 1'b1;
        dn_nx  = dn;
        if (!mode.center) begin
            dn_nx = 1'b0;
            if (eop) cnt_nx = '0;
        end else if (!dn) begin
            if (cnt >= prd) begin
                dn_nx  = 1'b1;
                cnt_nx = cnt - 1'b1;
            end
        end else if (cnt <= CW'(1)) begin
            cnt_nx = '0;
            dn_nx  = 1'b0;
        end else begin
            cnt_nx = cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            dn     <= 1'b0;
        end else if (stop) begin
            active <= 1'b0;
            cnt    <= '0;
            dn     <= 1'b0;
        end else if (launch) begin
            active <= 1'b1;
            cnt    <= '0;
            dn     <= 1'b0;
        end else if (step) begin
            cnt    <= cnt_nx;
            dn     <= dn_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            pval <= '0;
        end else if (stop || launch) begin
            pend <= 1'b0;
        end else if (wr_upd && active) begin
            pend <= 1'b1;
            pval <= wdata;
        end else if (eop) begin
            pend <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prd  <= '0;
            duty <= '0;
        end else if (!active) begin
            if (wr_prd)  prd  <= wdata;
            if (wr_duty) duty <= wdata;
        end else if (!stop && eop && pend) begin
            if (mode.upd_prd) prd  <= pval;
            else              duty <= pval;
        end
    end
endmodule

// File: rtl/pwm_events.sv
module pwm_events
    import pwm_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] eop,
    input  logic [NCH-1:0] ien,
    input  logic [NCH-1:0] clr,
    output logic [NCH-1:0] irq,
    output logic [NCH-1:0] status
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq    <= '0;
            status <= '0;
        end else begin
            irq    <= eop & ien;
            status <= (status & ~clr) | eop;
        end
    end
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
    import pwm_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    output logic [NCH-1:0] pwm_out,
    output logic [NCH-1:0] ch_active,
    output logic [NCH-1:0] irq_pulse,
    output logic [NCH-1:0] eop_status
);
    logic [NSRC-1:0] ticks;
    logic [NCH-1:0]  start_m, stop_m, clr_m, ien_q, eop_v, ch_we, pol_vec;
    logic            glb_we, ch_space;
    greg_e           greg;
    creg_e           creg;
    mode_t           mode_q [NCH];
    logic            unused_wr;

    assign unused_wr = ^wr_data[DW-1:CW];
    assign greg      = greg_e'(wr_addr[1:0]);
    assign creg      = creg_e'(wr_addr[1:0]);
    assign glb_we    = wr_en && !wr_addr[AW-1];
    assign ch_space  = wr_en && wr_addr[AW-1] && (wr_addr[AW-2:2+CHW] == '0);
    assign start_m   = (glb_we && greg == G_START) ? wr_data[NCH-1:0] : '0;
    assign stop_m    = (glb_we && greg == G_STOP)  ? wr_data[NCH-1:0] : '0;
    assign clr_m     = (glb_we && greg == G_CLR)   ? wr_data[NCH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst)                         ien_q <= '0;
        else if (glb_we && greg == G_IEN) ien_q <= wr_data[NCH-1:0];
    end

    pwm_prescaler u_pre (.clk(clk), .rst(rst), .tick(ticks));

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign ch_we[i]   = ch_space && (wr_addr[2 +: CHW] == CHW'(i));
        assign pol_vec[i] = mode_q[i].pol;

        always_ff @(posedge clk) begin
            if (rst)                          mode_q[i] <= '0;
            else if (ch_we[i] && creg == C_MODE) mode_q[i] <= mode_t'(wr_data[MODE_W-1:0]);
        end

        pwm_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .tick    (ticks),
            .start   (start_m[i]),
            .stop    (stop_m[i]),
            .mode    (mode_q[i]),
            .wr_prd  (ch_we[i] && creg == C_PRD),
            .wr_duty (ch_we[i] && creg == C_DUTY),
            .wr_upd  (ch_we[i] && creg == C_UPD),
            .wdata   (wr_data[CW-1:0]),
            .active  (ch_active[i]),
            .pwm     (pwm_out[i]),
            .eop     (eop_v[i])
        );
    end

    pwm_events u_evt (
        .clk    (clk),
        .rst    (rst),
        .eop    (eop_v),
        .ien    (ien_q),
        .clr    (clr_m),
        .irq    (irq_pulse),
        .status (eop_status)
    );
endmodule

// File: rtl/pwm_multi_chk.sv
module pwm_multi_chk
    import pwm_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           wr_en,
    input logic [AW-1:0]  wr_addr,
    input logic [DW-1:0]  wr_data,
    input logic [NCH-1:0] pwm_out,
    input logic [NCH-1:0] ch_active,
    input logic [NCH-1:0] irq_pulse,
    input logic [NCH-1:0] eop_status,
    input logic [NCH-1:0] pol_vec
);
    logic start_wr, stop_wr, clr_wr;
    assign start_wr = wr_en && !wr_addr[AW-1] && wr_addr[1:0] == 2'd0;
    assign stop_wr  = wr_en && !wr_addr[AW-1] && wr_addr[1:0] == 2'd1;
    assign clr_wr   = wr_en && !wr_addr[AW-1] && wr_addr[1:0] == 2'd3;

    // R6
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        ((~ch_active & (pwm_out ^ ~pol_vec)) == '0));

    // R9
    start_mask_chk: assert property (@(posedge clk) disable iff (rst)
        start_wr |=> ((ch_active & $past(wr_data[NCH-1:0])) == $past(wr_data[NCH-1:0])));

    // R10
    stop_mask_chk: assert property (@(posedge clk) disable iff (rst)
        stop_wr |=> ((ch_active & $past(wr_data[NCH-1:0])) == '0));

    // R11
    pulse_flags_chk: assert property (@(posedge clk) disable iff (rst)
        ((irq_pulse & ~eop_status) == '0));

    // R11
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_wr |=> ((~eop_status & $past(eop_status)) == '0));
endmodule

bind pwm_multi pwm_multi_chk u_chk (.*);

// File: tb/sim_pwm_multi.sv
module sim_pwm_multi;
    import pwm_pkg::*;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic [AW-1:0]  wr_addr = '0;
    logic [DW-1:0]  wr_data = '0;
    logic [NCH-1:0] pwm_out, ch_active, irq_pulse, eop_status;

    pwm_multi u0 (.*);

    always #5 clk = ~clk;

    int    checks = 0, failures = 0;
    string cur_req = "R1";
    bit    sync_chk = 1'b0;
    bit    started  = 1'b0;
    bit    done     = 1'b0;

    // behavioural reference state
    int m_cnt[NCH], m_prd[NCH], m_duty[NCH], m_pval[NCH], m_csel[NCH];
    bit m_en[NCH], m_dn[NCH], m_pend[NCH], m_ctr[NCH], m_pol[NCH], m_uprd[NCH];
    bit [NCH-1:0] m_stat, m_irq, m_ie;
    int m_div;

    function automatic bit [NCH-1:0] exp_pwm();
        bit [NCH-1:0] r;
        for (int c = 0; c < NCH; c++)
            r[c] = m_en[c] ? ((m_cnt[c] < m_duty[c]) ? m_pol[c] : !m_pol[c]) : !m_pol[c];
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin
                m_cnt[c] = 0; m_prd[c] = 0; m_duty[c] = 0; m_pval[c] = 0; m_csel[c] = 0;
                m_en[c] = 0; m_dn[c] = 0; m_pend[c] = 0; m_ctr[c] = 0; m_pol[c] = 0; m_uprd[c] = 0;
            end
            m_stat = '0; m_irq = '0; m_ie = '0; m_div = 0;
        end else begin
            bit [NCH-1:0] evt;
            bit           gl;
            int           d;
            gl = wr_en && !wr_addr[7];
            d  = int'(wr_data[15:0]);
            for (int c = 0; c < NCH; c++) begin
                bit tk, stp, last, chw, old_en;
                int msk;
                msk    = (1 << m_csel[c]) - 1;
                tk     = (m_div & msk) == msk;
                stp    = m_en[c] && tk;
                last   = m_ctr[c] ? (m_dn[c] && m_cnt[c] <= 1) : (m_cnt[c] + 1 >= m_prd[c]);
                evt[c] = stp && last;
                chw    = wr_en && wr_addr[7] && wr_addr[6:4] == 0 && wr_addr[3:2] == c;
                old_en = m_en[c];
                if (gl && wr_addr[1:0] == 1 && wr_data[c]) begin
                    m_en[c] = 0; m_cnt[c] = 0; m_dn[c] = 0; m_pend[c] = 0;
                end else if (gl && wr_addr[1:0] == 0 && wr_data[c] && !old_en) begin
                    m_en[c] = 1; m_cnt[c] = 0; m_dn[c] = 0; m_pend[c] = 0;
                end else if (old_en) begin
                    if (stp) begin
                        if (!m_ctr[c]) begin
                            m_cnt[c] = last ? 0 : m_cnt[c] + 1; m_dn[c] = 0;
                        end else if (!m_dn[c]) begin
                            if (m_cnt[c] >= m_prd[c]) begin m_dn[c] = 1; m_cnt[c]--; end
                            else m_cnt[c]++;
                        end else if (m_cnt[c] <= 1) begin
                            m_cnt[c] = 0; m_dn[c] = 0;
                        end else m_cnt[c]--;
                    end
                    if (evt[c] && m_pend[c]) begin
                        if (m_uprd[c]) m_prd[c] = m_pval[c];
                        else           m_duty[c] = m_pval[c];
                    end
                    if (chw && wr_addr[1:0] == 3) begin m_pend[c] = 1; m_pval[c] = d; end
                    else if (evt[c]) m_pend[c] = 0;
                end
                if (!old_en && chw && wr_addr[1:0] == 1) m_prd[c] = d;
                if (!old_en && chw && wr_addr[1:0] == 2) m_duty[c] = d;
                if (chw && wr_addr[1:0] == 0) begin
                    m_csel[c] = int'(wr_data[2:0]); m_ctr[c] = wr_data[3];
                    m_pol[c]  = wr_data[4];         m_uprd[c] = wr_data[5];
                end
            end
            m_stat = (m_stat & ~((gl && wr_addr[1:0] == 3) ? wr_data[NCH-1:0] : '0)) | evt;
            m_irq  = evt & m_ie;
            if (gl && wr_addr[1:0] == 2) m_ie = wr_data[NCH-1:0];
            m_div = (m_div + 1) & ((1 << (NSRC-1)) - 1);
        end
    end

    task automatic chk(input string what, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            chk("pwm_out", pwm_out, exp_pwm());
            chk("ch_active", ch_active, {m_en[3], m_en[2], m_en[1], m_en[0]});
            chk("irq_pulse", irq_pulse, m_irq);
            chk("eop_status", eop_status, m_stat);
            if (sync_chk) chk("R9 ch2 vs ch3", {pwm_out[3], ch_active[3]}, {pwm_out[2], ch_active[2]});
        end
    end

    task automatic wr(input logic [AW-1:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = DW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired, actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 pwm_out", pwm_out, '1);
        chk("R1 ch_active", ch_active, '0);
        chk("R1 irq_pulse", irq_pulse, '0);
        chk("R1 eop_status", eop_status, '0);
        started = 1'b1;

        cur_req = "R2";
        wr(8'h80, 32'h00); wr(8'h81, 5); wr(8'h82, 2);
        wr(8'h84, 32'h39); wr(8'h85, 4); wr(8'h86, 1);
        wr(8'h88, 32'h02); wr(8'h89, 6); wr(8'h8A, 3);
        wr(8'h8C, 32'h02); wr(8'h8D, 6); wr(8'h8E, 3);
        wr(8'h02, 32'h5);

        cur_req = "R9";
        sync_chk = 1'b1;
        wr(8'h00, 32'hF);
        idle(60);
        wr(8'h00, 32'h4);
        idle(10);
        sync_chk = 1'b0;

        cur_req = "R7";
        wr(8'h81, 9); wr(8'h82, 4);
        idle(30);

        cur_req = "R8";
        wr(8'h83, 4);
        idle(20);
        wr(8'h80, 32'h20);
        wr(8'h83, 8); wr(8'h83, 7);
        idle(40);
        wr(8'h87, 6);
        idle(60);

        cur_req = "R11";
        wr(8'h03, 32'hF);
        wr(8'h02, 32'hF);
        idle(30);
        wr(8'h03, 32'h3);
        idle(20);

        cur_req = "R10";
        wr(8'h87, 3);
        wr(8'h01, 32'h2);
        idle(10);
        wr(8'h00, 32'h2);
        idle(80);

        cur_req = "R5";
        wr(8'h80, 32'h13);
        idle(120);

        cur_req = "R4";
        wr(8'h88, 32'h08);
        idle(50);

        cur_req = "R3";
        wr(8'h01, 32'hF);
        wr(8'h8C, 32'h00); wr(8'h8D, 1); wr(8'h8E, 1);
        wr(8'h80, 32'h00); wr(8'h81, 15); wr(8'h82, 14);
        wr(8'h88, 32'h00); wr(8'h89, 4); wr(8'h8A, 0);
        wr(8'h84, 32'h10); wr(8'h85, 3); wr(8'h86, 3);
        wr(8'h00, 32'hF);
        idle(60);

        cur_req = "R6";
        wr(8'h01, 32'h3);
        idle(5);
        finish_run();
    end
endmodule